// File: doc/BRIEF.md
# Conditional-zero and compact integer unit

This unit sits in the execute stage of a 32-bit integer pipeline and evaluates two families of already decoded operations. The first family is the pair of conditional-zero operations, which let software build branchless selects: the result is either the first operand or zero, depending on whether the second operand is zero. The second family is a group of compact single-register operations used by short instruction forms: byte and halfword zero/sign extension, bitwise inversion, and a multiply that keeps only the low word of the product.

Compact operations carry a 3-bit register field that addresses the window of architectural registers 8 to 15. For these operations the destination register is also the first source, so the unit turns the 3-bit field into the 5-bit write-back index. Conditional-zero operations carry a full 5-bit destination that is passed through. The unit takes one operation per cycle and presents a registered result one cycle later. Operation codes outside the defined set produce a zero result and raise an illegal flag.

Top module: `czu_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs become zero on that edge regardless of the other inputs (synchronous active-high reset).
- R2: Operation code 0 (zero-if-zero): the result is 0 when `opnd_b` equals zero, otherwise `opnd_a`; `out_rd` equals `full_rd`.
- R3: Operation code 1 (zero-if-nonzero): the result is 0 when `opnd_b` is nonzero, otherwise `opnd_a`; `out_rd` equals `full_rd`.
- R4: For operation codes 2 to 7, `out_rd` equals 8 plus `cmp_rd` as a 5-bit value, and `full_rd` has no effect.
- R5: Code 2 returns bits 7:0 of `opnd_a` with bits 31:8 cleared; code 3 returns bits 7:0 of `opnd_a` with bit 7 copied into bits 31:8.
- R6: Code 4 returns bits 15:0 of `opnd_a` with bits 31:16 cleared; code 5 returns bits 15:0 of `opnd_a` with bit 15 copied into bits 31:16.
- R7: Code 6 returns `opnd_a` XOR all ones; `opnd_b` has no effect on the result for codes 2 to 6.
- R8: Code 7 returns the low 32 bits of the unsigned product `opnd_a * opnd_b`; higher product bits are discarded.
- R9: Codes 8 to 15 give `out_result` 0, `out_rd` 0 and `out_illegal` 1; codes 0 to 7 give `out_illegal` 0.
- R10: A cycle with `in_valid` low yields, one cycle later, `out_valid`, `out_result`, `out_rd` and `out_illegal` all zero.
- R11: An operation accepted with `in_valid` high at one edge appears with `out_valid` high exactly one edge later, and a new operation may be accepted on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Decoded operation code (0..7 defined) |
| opnd_a | input | 32 | First operand; value of the destination register for compact operations |
| opnd_b | input | 32 | Second operand (condition for conditional-zero, multiplier for code 7) |
| full_rd | input | 5 | Destination index for conditional-zero operations |
| cmp_rd | input | 3 | Compressed destination field for compact operations |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Registered result |
| out_rd | output | 5 | Registered destination register index |
| out_illegal | output | 1 | Registered flag for an undefined operation code |

## Verification
The register that captures the result of one operation is loaded on the same edge at which the next operation is decoded, so a conditional-zero result, a compact result with its remapped index and an illegal code can sit on neighbouring cycles with no gap. The bench provokes this by streaming operations every cycle with the classes shuffled, idle cycles and illegal codes mixed in, and reset asserted while `in_valid` is high. Each cycle the outputs are compared with a behavioural model that queues the expected value of the previous cycle, so a result that leaks into the wrong cycle, or an index from the wrong field, is caught.

// File: rtl/czu_pkg.sv
package czu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_CZ_ZERO_IF_Z  = 4'd0,
    OP_CZ_ZERO_IF_NZ = 4'd1,
    OP_BYTE_ZX       = 4'd2,
    OP_BYTE_SX       = 4'd3,
    OP_HALF_ZX       = 4'd4,
    OP_HALF_SX       = 4'd5,
    OP_INVERT        = 4'd6,
    OP_MUL_LO        = 4'd7
  } czu_op_e;

  // Number of extension widths generated (byte, halfword)
  localparam int EXT_VARIANTS = 2;
  localparam int EXT_BASE_W   = 8;

endpackage

// File: rtl/czu_condzero.sv
// Branchless select: passes the value through or forces zero depending on
// whether the condition operand is zero.
module czu_condzero #(
  parameter int XLEN            = 32,
  parameter bit ZERO_ON_NONZERO = 1'b0
) (
  input  logic [XLEN-1:0] value_i,
  input  logic [XLEN-1:0] cond_i,
  output logic [XLEN-1:0] result_o
);

  logic cond_is_zero;
  logic kill;

  assign cond_is_zero = (cond_i == '0);

  generate
    if (ZERO_ON_NONZERO) begin : g_nz
      assign kill = !cond_is_zero;
    end else begin : g_z
      assign kill = cond_is_zero;
    end
  endgenerate

  assign result_o = kill ? '0 : value_i;

endmodule

// File: rtl/czu_extend.sv
// Widens a narrow field to XLEN bits, both with zero fill and sign fill.
module czu_extend #(
  parameter int XLEN   = 32,
  parameter int FROM_W = 8
) (
  input  logic [FROM_W-1:0] src_i,
  output logic [XLEN-1:0]   zext_o,
  output logic [XLEN-1:0]   sext_o
);

  localparam int FILL_W = XLEN - FROM_W;

  assign zext_o = {{FILL_W{1'b0}}, src_i};
  assign sext_o = {{FILL_W{src_i[FROM_W-1]}}, src_i};

endmodule

// File: rtl/czu_regmap.sv
// Maps a compressed register field onto the architectural register window.
module czu_regmap #(
  parameter int CREG_W = 3,
  parameter int REG_W  = 5,
  parameter int BASE   = 8
) (
  input  logic [CREG_W-1:0] cidx_i,
  output logic [REG_W-1:0]  ridx_o
);

  assign ridx_o = REG_W'(BASE) + REG_W'(cidx_i);

endmodule

// File: rtl/czu_mul_lo.sv
// Multiplier that returns only the low XLEN bits of the product.
module czu_mul_lo #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] prod_o
);

  assign prod_o = a_i * b_i;

endmodule

// File: rtl/czu_top.sv
module czu_top
  import czu_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_W     = 5,
  parameter int CREG_W    = 3,
  parameter int CREG_BASE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  op_sel,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [REG_W-1:0]  full_rd,
  input  logic [CREG_W-1:0] cmp_rd,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_result,
  output logic [REG_W-1:0]  out_rd,
  output logic              out_illegal
);

  // ---------------- datapath units ----------------
  logic [XLEN-1:0] cz_res [2];
  logic [XLEN-1:0] ext_z  [EXT_VARIANTS];
  logic [XLEN-1:0] ext_s  [EXT_VARIANTS];
  logic [XLEN-1:0] mul_res;
  logic [REG_W-1:0] window_rd;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_cz
      czu_condzero #(
        .XLEN           (XLEN),
        .ZERO_ON_NONZERO(g[0])
      ) u_cz (
        .value_i (opnd_a),
        .cond_i  (opnd_b),
        .result_o(cz_res[g])
      );
    end

    for (genvar g = 0; g < EXT_VARIANTS; g++) begin : g_ext
      localparam int W = EXT_BASE_W << g;
      czu_extend #(
        .XLEN  (XLEN),
        .FROM_W(W)
      ) u_ext (
        .src_i (opnd_a[W-1:0]),
        .zext_o(ext_z[g]),
        .sext_o(ext_s[g])
      );
    end
  endgenerate

  czu_mul_lo #(
    .XLEN(XLEN)
  ) u_mul (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .prod_o(mul_res)
  );

  czu_regmap #(
    .CREG_W(CREG_W),
    .REG_W (REG_W),
    .BASE  (CREG_BASE)
  ) u_map (
    .cidx_i(cmp_rd),
    .ridx_o(window_rd)
  );

  // ---------------- operation select ----------------
  logic [XLEN-1:0]  nxt_result;
  logic [REG_W-1:0] nxt_rd;
  logic             nxt_illegal;

  always_comb begin
    nxt_result  = '0;
    nxt_rd      = window_rd;
    nxt_illegal = 1'b0;
    case (op_sel)
      OP_CZ_ZERO_IF_Z: begin
        nxt_result = cz_res[0];
        nxt_rd     = full_rd;
      end
      OP_CZ_ZERO_IF_NZ: begin
        nxt_result = cz_res[1];
        nxt_rd     = full_rd;
      end
      OP_BYTE_ZX: nxt_result = ext_z[0];
      OP_BYTE_SX: nxt_result = ext_s[0];
      OP_HALF_ZX: nxt_result = ext_z[1];
      OP_HALF_SX: nxt_result = ext_s[1];
      OP_INVERT:  nxt_result = opnd_a ^ {XLEN{1'b1}};
      OP_MUL_LO:  nxt_result = mul_res;
      default: begin
        nxt_result  = '0;
        nxt_rd      = '0;
        nxt_illegal = 1'b1;
      end
    endcase
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_rd      <= '0;
      out_illegal <= 1'b0;
    end else if (in_valid) begin
      out_valid   <= 1'b1;
      out_result  <= nxt_result;
      out_rd      <= nxt_rd;
      out_illegal <= nxt_illegal;
    end else begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_rd      <= '0;
      out_illegal <= 1'b0;
    end
  end

endmodule

// File: rtl/czu_top_chk.sv
module czu_top_chk #(
  parameter int XLEN      = 32,
  parameter int REG_W     = 5,
  parameter int CREG_W    = 3,
  parameter int CREG_BASE = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op_sel,
  input logic [XLEN-1:0]   opnd_a,
  input logic [XLEN-1:0]   opnd_b,
  input logic [REG_W-1:0]  full_rd,
  input logic [CREG_W-1:0] cmp_rd,
  input logic              out_valid,
  input logic [XLEN-1:0]   out_result,
  input logic [REG_W-1:0]  out_rd,
  input logic              out_illegal
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && out_rd == '0 && !out_illegal)); // R1

  AST_CZ_Z_KILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd0 && opnd_b == '0) |=> (out_result == '0)); // R2

  AST_CZ_Z_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd0 && opnd_b != '0)
      |=> (out_result == $past(opnd_a) && out_rd == $past(full_rd))); // R2

  AST_CZ_NZ_KILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd1 && opnd_b != '0) |=> (out_result == '0)); // R3

  AST_COMPACT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel >= 4'd2 && op_sel <= 4'd7)
      |=> (out_rd - REG_W'(CREG_BASE) == REG_W'($past(cmp_rd)))); // R4

  AST_BYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd3)
      |=> ($countones(out_result[XLEN-1:7]) == 0 ||
           $countones(out_result[XLEN-1:7]) == XLEN - 7)); // R5

  AST_INVERT_ALL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd6) |=> ((out_result & $past(opnd_a)) == '0)); // R7

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_valid && out_result == '0 && out_rd == '0)); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_result == '0 && !out_illegal)); // R10

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R11

endmodule

bind czu_top czu_top_chk #(
  .XLEN     (XLEN),
  .REG_W    (REG_W),
  .CREG_W   (CREG_W),
  .CREG_BASE(CREG_BASE)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op_sel     (op_sel),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .full_rd    (full_rd),
  .cmp_rd     (cmp_rd),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_rd     (out_rd),
  .out_illegal(out_illegal)
);

// File: tb/czu_top_tb.sv
`timescale 1ns/1ps
module czu_top_tb_top;

  localparam int WD_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  full_rd = '0;
  logic [2:0]  cmp_rd = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [4:0]  out_rd;
  logic        out_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  czu_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .full_rd(full_rd), .cmp_rd(cmp_rd),
    .out_valid(out_valid), .out_result(out_result), .out_rd(out_rd),
    .out_illegal(out_illegal)
  );

  typedef struct {
    bit          v;
    logic [31:0] res;
    logic [4:0]  rd;
    bit          ill;
    string       tag;
    string       rd_tag;
  } exp_t;

  exp_t exp_q[$];

  function automatic exp_t model(bit r, bit v, logic [3:0] op, logic [31:0] a,
                                 logic [31:0] b, logic [4:0] rd, logic [2:0] crd);
    exp_t e;
    logic [63:0] wide;
    e.v = 0; e.res = 0; e.rd = 0; e.ill = 0; e.tag = "R10"; e.rd_tag = "R10";
    if (r) begin e.tag = "R1"; e.rd_tag = "R1"; return e; end
    if (!v) return e;
    e.v = 1;
    e.rd = 5'(8 + int'(crd));
    e.rd_tag = "R4";
    case (op)
      4'd0: begin e.res = (b == 0) ? 32'd0 : a; e.rd = rd; e.tag = "R2"; e.rd_tag = "R2"; end
      4'd1: begin e.res = (b != 0) ? 32'd0 : a; e.rd = rd; e.tag = "R3"; e.rd_tag = "R3"; end
      4'd2: begin e.res = a & 32'h0000_00FF; e.tag = "R5"; end
      4'd3: begin e.res = 32'($signed(a[7:0])); e.tag = "R5"; end
      4'd4: begin e.res = a & 32'h0000_FFFF; e.tag = "R6"; end
      4'd5: begin e.res = 32'($signed(a[15:0])); e.tag = "R6"; end
      4'd6: begin e.res = ~a; e.tag = "R7"; end
      4'd7: begin wide = 64'(a) * 64'(b); e.res = wide[31:0]; e.tag = "R8"; end
      default: begin e.res = 0; e.rd = 0; e.ill = 1; e.tag = "R9"; e.rd_tag = "R9"; end
    endcase
    return e;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (out_result !== e.res || out_illegal !== e.ill) begin
      failures++;
      $display("FAIL %s result/illegal: got %h/%b expected %h/%b",
               e.tag, out_result, out_illegal, e.res, e.ill);
    end
    checks++;
    if (out_rd !== e.rd) begin
      failures++;
      $display("FAIL %s rd: got %0d expected %0d", e.rd_tag, out_rd, e.rd);
    end
    checks++;
    if (out_valid !== e.v) begin
      failures++;
      // R11: valid must follow an accepted operation by exactly one edge
      $display("FAIL %s valid: got %b expected %b", e.v ? "R11" : e.tag, out_valid, e.v);
    end
  endtask

  // One clock step: check the previous cycle's outputs, then drive new inputs.
  task automatic step(bit r, bit v, logic [3:0] op, logic [31:0] a,
                      logic [31:0] b, logic [4:0] rd, logic [2:0] crd);
    @(negedge clk);
    if (exp_q.size() > 0) compare(exp_q.pop_front());
    rst = r; in_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
    full_rd = rd; cmp_rd = crd;
    exp_q.push_back(model(r, v, op, a, b, rd, crd));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    // R1: reset with a live operation on the inputs
    step(1, 1, 4'd6, 32'h1234_5678, 32'h1, 5'd3, 3'd2);
    step(1, 1, 4'd7, 32'hFFFF_FFFF, 32'h2, 5'd9, 3'd5);
    step(1, 0, 4'd0, 32'h0, 32'h0, 5'd0, 3'd0);
    // R2: zero-if-zero with condition zero, positive, negative
    step(0, 1, 4'd0, 32'hDEAD_BEEF, 32'h0, 5'd17, 3'd1);
    step(0, 1, 4'd0, 32'hDEAD_BEEF, 32'h5, 5'd31, 3'd1);
    step(0, 1, 4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd1, 3'd1);
    // R3: zero-if-nonzero
    step(0, 1, 4'd1, 32'hCAFE_F00D, 32'h0, 5'd4, 3'd6);
    step(0, 1, 4'd1, 32'hCAFE_F00D, 32'h1, 5'd5, 3'd6);
    step(0, 1, 4'd1, 32'h0000_0000, 32'h8000_0000, 5'd0, 3'd6);
    // R5 / R4: byte extension, window ends x8 and x15
    step(0, 1, 4'd2, 32'hFFFF_FF80, 32'h0, 5'd22, 3'd0);
    step(0, 1, 4'd3, 32'h0000_0080, 32'h0, 5'd22, 3'd7);
    step(0, 1, 4'd3, 32'hFFFF_FF7F, 32'h0, 5'd22, 3'd3);
    // R6: halfword extension
    step(0, 1, 4'd4, 32'hABCD_8001, 32'h0, 5'd2, 3'd4);
    step(0, 1, 4'd5, 32'h0000_8001, 32'h0, 5'd2, 3'd4);
    step(0, 1, 4'd5, 32'hFFFF_7FFF, 32'h0, 5'd2, 3'd4);
    // R7: inversion, same operand with different second operand
    step(0, 1, 4'd6, 32'h0F0F_00FF, 32'h0, 5'd9, 3'd2);
    step(0, 1, 4'd6, 32'h0F0F_00FF, 32'hFFFF_FFFF, 5'd9, 3'd2);
    // R8: multiply with discarded high bits
    step(0, 1, 4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 3'd5);
    step(0, 1, 4'd7, 32'h0001_0000, 32'h0001_0000, 5'd0, 3'd5);
    step(0, 1, 4'd7, 32'h0000_1234, 32'h0000_0010, 5'd0, 3'd5);
    // R9: undefined codes
    step(0, 1, 4'd8, 32'h1111_1111, 32'h2222_2222, 5'd12, 3'd3);
    step(0, 1, 4'd15, 32'hFFFF_FFFF, 32'h0, 5'd31, 3'd7);
    // R10: idle cycle with busy operand lines
    step(0, 0, 4'd6, 32'h5555_AAAA, 32'h3, 5'd7, 3'd7);
    step(0, 1, 4'd0, 32'h7777_7777, 32'h1, 5'd14, 3'd0);
    // R11: back-to-back mixed stream with occasional idle and reset
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [3:0] op;
      a = $urandom;
      b = $urandom;
      if (($urandom % 4) == 0) b = 0;
      if (($urandom % 8) == 0) a = {{24{a[7]}}, a[7:0]} ^ 32'h0000_FF00;
      op = ($urandom % 6 == 0) ? 4'($urandom) : 4'($urandom % 8);
      step(($urandom % 200) == 0, ($urandom % 7) != 0, op, a, b,
           5'($urandom), 3'($urandom));
    end
    step(0, 0, 4'd0, 32'h0, 32'h0, 5'd0, 3'd0);
    step(0, 0, 4'd0, 32'h0, 32'h0, 5'd0, 3'd0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(WD_CYCLES * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

endmodule